// File: doc/BRIEF.md
# Linked-List Memory-to-Stream Transfer Engine

This block is a single-channel engine that moves words from memory onto a valid/ready output stream. It works through a chain of four-word data descriptors kept in memory. For each descriptor it fetches the four words through a word-wide read port. It then reads the payload from the buffer start up to, but not including, the buffer end, and sends each word as one stream beat. When the payload is done it writes the flags word back and moves on to the descriptor named by the next pointer.

Packets are defined by descriptor flags, so one packet can span several descriptors. A 16-bit metadata value from the first descriptor of each packet is emitted on a sideband strobe before that packet's data. The chain stops at a descriptor marked end-of-list. At that point the engine latches an end-of-list flag, writes a disable word to a context address and halts. Software can later clear the marker in memory, point the next field further and issue a continue request to extend the chain.

The control is one state machine:
- `S_IDLE`: after reset.
- `S_FETCH`: four descriptor reads.
- `S_META`: one-cycle metadata strobe.
- `S_DREAD`: payload read.
- `S_DSEND`: beat held until accepted.
- `S_WBACK`: flags write-back.
- `S_CTXWR`: context disable write.
- `S_HALT`: stopped at end of list.

Transitions:
- start: `S_IDLE`/`S_HALT` to `S_FETCH`.
- fetch-done: `S_FETCH` to `S_META` or `S_DREAD`.
- meta-sent: `S_META` to `S_DREAD`.
- word-in: `S_DREAD` to `S_DSEND`.
- beat-out: `S_DSEND` to `S_DREAD`.
- buffer-done: `S_DREAD` to `S_WBACK`.
- chain-next: `S_WBACK` to `S_FETCH`.
- chain-end: `S_WBACK` to `S_CTXWR`.
- ctx-done: `S_CTXWR` to `S_HALT`.
- continue: `S_HALT` to `S_FETCH` in re-read mode.
- reread-advance: `S_FETCH` to `S_FETCH`.
- reread-stay: `S_FETCH` to `S_HALT`.

Top module: `dstream_out_engine`

## Requirements
- R1: After reset, no read or write request is raised, no beat or metadata strobe is presented, and `running_o` and `eol_o` are 0.
- R2: A descriptor at byte address A is read as four word reads, at A, A+4, A+8 and A+12, in that order. These words are the next pointer, the buffer start, the flags and the exclusive buffer end. Each read request keeps its address until `rd_valid_i`.
- R3: Payload words are read from the buffer start up to the buffer end minus 4, in rising address order, and each is sent as one beat. The beat is held unchanged while `m_ready_i` is low.
- R4: `m_last_o` is 1 only on the final beat of a descriptor whose flags bit 3 (output end of packet) is 1.
- R5: Before the first data beat of a packet, `md_valid_o` pulses for one cycle with flags bits 31:16 on `md_data_o`. A packet starts at the first descriptor after a start command, and at any descriptor that follows one with flags bit 3 set.
- R6: After the last payload beat of a descriptor, its flags word is written back unchanged to A+8.
- R7: If flags bit 4 is set, `irq_o` pulses for one cycle in the cycle the write-back is acknowledged.
- R8: If flags bit 0 (end of list) is clear, the engine next fetches the descriptor at the next pointer.
- R9: If flags bit 0 is set, `eol_o` becomes 1 and the word 0x00008000 (disable bit 15) is written to `ctx_addr_i`. The engine then halts and makes no further reads.
- R10: A continue request while halted re-reads the current descriptor. If bit 0 is now clear, `eol_o` clears and the engine follows the re-read next pointer. If bit 0 is still set, the engine stays halted with `eol_o` at 1.
- R11: A continue request is ignored, with no read issued and `eol_o` kept, while `stop_i` is 1 or `enable_i` is 0.
- R12: A start command (with `enable_i` at 1, from idle or halt) clears `eol_o`, sets `running_o` and begins at `desc_ptr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Channel enable |
| stop_i | input | 1 | Channel stopped; blocks continue |
| start_i | input | 1 | Start pulse |
| desc_ptr_i | input | AW | First descriptor address for start |
| cont_i | input | 1 | Continue request pulse |
| ctx_addr_i | input | AW | Address of the context disable word |
| rd_req_o | output | 1 | Memory read request |
| rd_addr_o | output | AW | Memory read byte address |
| rd_valid_i | input | 1 | Read response valid |
| rd_data_i | input | 32 | Read response data |
| wr_req_o | output | 1 | Memory write request |
| wr_addr_o | output | AW | Memory write byte address |
| wr_data_o | output | 32 | Memory write data |
| wr_ack_i | input | 1 | Write acknowledge |
| m_valid_o | output | 1 | Stream beat valid |
| m_ready_i | input | 1 | Stream sink ready |
| m_data_o | output | 32 | Stream beat data |
| m_last_o | output | 1 | Final beat of a packet |
| md_valid_o | output | 1 | Metadata strobe |
| md_data_o | output | 16 | Packet metadata |
| irq_o | output | 1 | Data-interrupt event pulse |
| running_o | output | 1 | Channel has been started |
| eol_o | output | 1 | Latched end-of-list |

## Verification
- **Memory latency:** every memory access costs two cycles in the bench memory. The response arrives one cycle after the request is seen, so a descriptor fetch takes eight cycles and each payload word at least two more before its beat can appear.
- **Sampling:** the monitor samples one nanosecond after each falling edge. It counts a beat or metadata strobe only when it is visible then, and scores a write or an interrupt in the cycle the acknowledge is raised.
- **Fixed-offset checks:** are placed where the count is exact. The flag clear after a start is checked two cycles later, before any fetch can finish. After a continue, the clear is checked ten cycles later: after the four re-read responses (about eight cycles) but well before the next descriptor's payload can finish.
- **Ignored continues:** these are observed as the absence of any read over twenty cycles.

// File: rtl/dso_pkg.sv
package dso_pkg;
    localparam int WORD_W      = 32;
    localparam int DESC_WORDS  = 4;
    localparam int IDX_W       = $clog2(DESC_WORDS);
    localparam int MD_W        = 16;
    // flags word bit positions
    localparam int FL_EOL      = 0;
    localparam int FL_OEOP     = 3;
    localparam int FL_IRQ      = 4;
    localparam int FL_MD_LSB   = 16;
    localparam logic [WORD_W-1:0] CTX_DIS_WORD = 32'h0000_8000;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_META, S_DREAD, S_DSEND, S_WBACK, S_CTXWR, S_HALT
    } dso_state_e;
endpackage

// File: rtl/dso_desc_store.sv
module dso_desc_store
    import dso_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [WORD_W-1:0] din_i,
    output logic [WORD_W-1:0] next_o,
    output logic [WORD_W-1:0] buf_o,
    output logic [WORD_W-1:0] flags_o,
    output logic [WORD_W-1:0] end_o
);
    logic [WORD_W-1:0] word_q [DESC_WORDS];

    for (genvar g = 0; g < DESC_WORDS; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                word_q[g] <= '0;
            else if (we_i && (idx_i == IDX_W'(g)))
                word_q[g] <= din_i;
        end
    end

    assign next_o  = word_q[0];
    assign buf_o   = word_q[1];
    assign flags_o = word_q[2];
    assign end_o   = word_q[3];
endmodule

// File: rtl/dso_ctrl.sv
module dso_ctrl
    import dso_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              stop_i,
    input  logic              start_i,
    input  logic [AW-1:0]     desc_ptr_i,
    input  logic              cont_i,
    input  logic [AW-1:0]     ctx_addr_i,
    output logic              rd_req_o,
    output logic [AW-1:0]     rd_addr_o,
    input  logic              rd_valid_i,
    input  logic [WORD_W-1:0] rd_data_i,
    output logic              wr_req_o,
    output logic [AW-1:0]     wr_addr_o,
    output logic [WORD_W-1:0] wr_data_o,
    input  logic              wr_ack_i,
    output logic              m_valid_o,
    input  logic              m_ready_i,
    output logic [WORD_W-1:0] m_data_o,
    output logic              m_last_o,
    output logic              md_valid_o,
    output logic [MD_W-1:0]   md_data_o,
    output logic              irq_o,
    output logic              running_o,
    output logic              eol_o,
    output logic              st_we_o,
    output logic [IDX_W-1:0]  st_idx_o,
    input  logic [AW-1:0]     next_i,
    input  logic [AW-1:0]     buf_i,
    input  logic [WORD_W-1:0] flags_i,
    input  logic [AW-1:0]     end_i
);
    localparam logic [AW-1:0] STEP = AW'(WORD_W / 8);
    localparam logic [AW-1:0] FLAGS_OFF = AW'(2 * (WORD_W / 8));

    dso_state_e         state_q, state_d;
    logic [IDX_W-1:0]   idx_q;
    logic [AW-1:0]      cur_q, ptr_q;
    logic [WORD_W-1:0]  beat_q;
    logic               eol_q, run_q, pkt_q, reread_q;
    logic               go_start, go_cont, buf_done, last_word;

    assign go_start  = start_i && enable_i;
    assign go_cont   = cont_i && enable_i && !stop_i && run_q && flags_i[FL_EOL];
    assign buf_done  = (ptr_q == end_i);
    assign last_word = (idx_q == IDX_W'(DESC_WORDS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (go_start) state_d = S_FETCH;
            S_FETCH: if (rd_valid_i && last_word) begin
                         if (reread_q) state_d = flags_i[FL_EOL] ? S_HALT : S_FETCH;
                         else          state_d = pkt_q ? S_META : S_DREAD;
                     end
            S_META:  state_d = S_DREAD;
            S_DREAD: if (buf_done)        state_d = S_WBACK;
                     else if (rd_valid_i) state_d = S_DSEND;
            S_DSEND: if (m_ready_i) state_d = S_DREAD;
            S_WBACK: if (wr_ack_i) state_d = flags_i[FL_EOL] ? S_CTXWR : S_FETCH;
            S_CTXWR: if (wr_ack_i) state_d = S_HALT;
            S_HALT:  if (go_start || go_cont) state_d = S_FETCH;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0; cur_q <= '0; ptr_q <= '0; beat_q <= '0;
            eol_q <= 1'b0; run_q <= 1'b0; pkt_q <= 1'b0; reread_q <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE, S_HALT: begin
                    if (go_start) begin
                        cur_q <= desc_ptr_i; eol_q <= 1'b0; run_q <= 1'b1;
                        pkt_q <= 1'b1; reread_q <= 1'b0; idx_q <= '0;
                    end else if (state_q == S_HALT && go_cont) begin
                        reread_q <= 1'b1; idx_q <= '0;
                    end
                end
                S_FETCH: if (rd_valid_i) begin
                    idx_q <= idx_q + IDX_W'(1);
                    if (last_word) begin
                        reread_q <= 1'b0;
                        if (!reread_q) begin
                            ptr_q <= buf_i;
                        end else if (!flags_i[FL_EOL]) begin
                            cur_q <= next_i; eol_q <= 1'b0;
                        end
                    end
                end
                S_META:  pkt_q <= 1'b0;
                S_DREAD: if (!buf_done && rd_valid_i) beat_q <= rd_data_i;
                S_DSEND: if (m_ready_i) ptr_q <= ptr_q + STEP;
                S_WBACK: if (wr_ack_i) begin
                    pkt_q <= flags_i[FL_OEOP];
                    if (flags_i[FL_EOL]) eol_q <= 1'b1;
                    else                 cur_q <= next_i;
                end
                S_CTXWR: ;
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_req_o   = 1'b0;
        rd_addr_o  = ptr_q;
        wr_req_o   = 1'b0;
        wr_addr_o  = cur_q + FLAGS_OFF;
        wr_data_o  = flags_i;
        m_valid_o  = 1'b0;
        m_last_o   = 1'b0;
        md_valid_o = 1'b0;
        irq_o      = 1'b0;
        st_we_o    = 1'b0;
        unique case (state_q)
            S_FETCH: begin
                rd_req_o  = 1'b1;
                rd_addr_o = cur_q + AW'({idx_q, 2'b00});
                st_we_o   = rd_valid_i;
            end
            S_META:  md_valid_o = 1'b1;
            S_DREAD: rd_req_o = !buf_done;
            S_DSEND: begin
                m_valid_o = 1'b1;
                m_last_o  = flags_i[FL_OEOP] && ((ptr_q + STEP) == end_i);
            end
            S_WBACK: begin
                wr_req_o = 1'b1;
                irq_o    = wr_ack_i && flags_i[FL_IRQ];
            end
            S_CTXWR: begin
                wr_req_o  = 1'b1;
                wr_addr_o = ctx_addr_i;
                wr_data_o = CTX_DIS_WORD;
            end
            default: ;
        endcase
    end

    assign m_data_o  = beat_q;
    assign md_data_o = flags_i[FL_MD_LSB +: MD_W];
    assign st_idx_o  = idx_q;
    assign running_o = run_q;
    assign eol_o     = eol_q;

    // R3: an offered beat stays put until taken
    assert_beat_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid_o && !m_ready_i |=> m_valid_o && $stable(m_data_o) && $stable(m_last_o));
    // R2: a pending read keeps its address
    assert_rd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o && !rd_valid_i |=> rd_req_o && $stable(rd_addr_o));
    // R6: a pending write keeps address and data
    assert_wr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o && !wr_ack_i |=> wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o));
    // R9: a halted channel presents nothing on the stream
    assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        eol_o |-> !m_valid_o && !md_valid_o);
    // R7: the interrupt event coincides with an acknowledged write
    assert_irq_on_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> wr_req_o && wr_ack_i);
    // R5: metadata strobe is a single cycle and never alongside a beat
    assert_md_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        md_valid_o |=> !md_valid_o && !m_valid_o);
endmodule

// File: rtl/dstream_out_engine.sv
module dstream_out_engine
    import dso_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              stop_i,
    input  logic              start_i,
    input  logic [AW-1:0]     desc_ptr_i,
    input  logic              cont_i,
    input  logic [AW-1:0]     ctx_addr_i,
    output logic              rd_req_o,
    output logic [AW-1:0]     rd_addr_o,
    input  logic              rd_valid_i,
    input  logic [31:0]       rd_data_i,
    output logic              wr_req_o,
    output logic [AW-1:0]     wr_addr_o,
    output logic [31:0]       wr_data_o,
    input  logic              wr_ack_i,
    output logic              m_valid_o,
    input  logic              m_ready_i,
    output logic [31:0]       m_data_o,
    output logic              m_last_o,
    output logic              md_valid_o,
    output logic [15:0]       md_data_o,
    output logic              irq_o,
    output logic              running_o,
    output logic              eol_o
);
    logic              st_we;
    logic [IDX_W-1:0]  st_idx;
    logic [WORD_W-1:0] next_w, buf_w, flags_w, end_w;

    dso_desc_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (st_we),
        .idx_i   (st_idx),
        .din_i   (rd_data_i),
        .next_o  (next_w),
        .buf_o   (buf_w),
        .flags_o (flags_w),
        .end_o   (end_w)
    );

    dso_ctrl #(.AW(AW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (enable_i),
        .stop_i     (stop_i),
        .start_i    (start_i),
        .desc_ptr_i (desc_ptr_i),
        .cont_i     (cont_i),
        .ctx_addr_i (ctx_addr_i),
        .rd_req_o   (rd_req_o),
        .rd_addr_o  (rd_addr_o),
        .rd_valid_i (rd_valid_i),
        .rd_data_i  (rd_data_i),
        .wr_req_o   (wr_req_o),
        .wr_addr_o  (wr_addr_o),
        .wr_data_o  (wr_data_o),
        .wr_ack_i   (wr_ack_i),
        .m_valid_o  (m_valid_o),
        .m_ready_i  (m_ready_i),
        .m_data_o   (m_data_o),
        .m_last_o   (m_last_o),
        .md_valid_o (md_valid_o),
        .md_data_o  (md_data_o),
        .irq_o      (irq_o),
        .running_o  (running_o),
        .eol_o      (eol_o),
        .st_we_o    (st_we),
        .st_idx_o   (st_idx),
        .next_i     (next_w[AW-1:0]),
        .buf_i      (buf_w[AW-1:0]),
        .flags_i    (flags_w),
        .end_i      (end_w[AW-1:0])
    );
endmodule

// File: tb/sim_dstream_out_engine.sv
`timescale 1ns/1ps
module sim_dstream_out_engine;
    localparam int CTX = 32'h3F0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable_i = 1'b1, stop_i = 1'b0, start_i = 1'b0, cont_i = 1'b0;
    logic [31:0] desc_ptr_i = '0;
    logic [31:0] ctx_addr_i = CTX;
    logic rd_req_o, rd_valid_i = 1'b0;
    logic [31:0] rd_addr_o, rd_data_i = '0;
    logic wr_req_o, wr_ack_i = 1'b0;
    logic [31:0] wr_addr_o, wr_data_o;
    logic m_valid_o, m_ready_i = 1'b0, m_last_o;
    logic [31:0] m_data_o;
    logic md_valid_o;
    logic [15:0] md_data_o;
    logic irq_o, running_o, eol_o;

    always #4 clk = ~clk;

    dstream_out_engine u0 (.*);

    logic [31:0] mem [0:255];
    logic [31:0] q_rd[$];
    logic [32:0] q_beat[$];
    logic [15:0] q_md[$];
    logic [63:0] q_wr[$];
    int n_cmp = 0, n_bad = 0, cyc = 0, irq_seen = 0, irq_exp = 0;
    bit exp_pkt = 1'b1;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic put_desc(input int a, input int nxt, input int b, input int flg, input int e);
        mem[a >> 2] = nxt; mem[(a >> 2) + 1] = b; mem[(a >> 2) + 2] = flg; mem[(a >> 2) + 3] = e;
    endtask

    task automatic expect_refetch(input int a);
        for (int i = 0; i < 4; i++) q_rd.push_back(a + 4 * i);
    endtask

    // driver: push everything one descriptor should produce
    task automatic expect_desc(input int a);
        logic [31:0] b, e, f;
        b = mem[(a >> 2) + 1]; f = mem[(a >> 2) + 2]; e = mem[(a >> 2) + 3];
        expect_refetch(a);
        if (exp_pkt) q_md.push_back(f[31:16]);
        for (int k = b; k < e; k += 4) begin
            q_rd.push_back(k);
            q_beat.push_back({f[3] && (k == e - 4), mem[k >> 2]});
        end
        q_wr.push_back({a + 32'd8, f});
        if (f[4]) irq_exp++;
        exp_pkt = f[3];
        if (f[0]) q_wr.push_back({32'(CTX), 32'h0000_8000});
    endtask

    // memory model and stream monitor
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
        if (rd_valid_i) rd_valid_i = 1'b0;
        else if (rd_req_o) begin
            rd_valid_i = 1'b1;
            rd_data_i  = mem[rd_addr_o[9:2]];
            if (q_rd.size() == 0) chk("R2/R11 unexpected read", rd_addr_o, 64'hFFFF_FFFF_FFFF);
            else chk("R2 read address", rd_addr_o, q_rd.pop_front());
        end
        if (wr_ack_i) wr_ack_i = 1'b0;
        else if (wr_req_o) begin
            wr_ack_i = 1'b1;
            mem[wr_addr_o[9:2]] = wr_data_o;
            if (q_wr.size() == 0) chk("R6 unexpected write", {wr_addr_o, wr_data_o}, '1);
            else chk("R6/R9 write", {wr_addr_o, wr_data_o}, q_wr.pop_front());
        end
        m_ready_i = !((cyc % 5 == 1) || (cyc % 5 == 2));
        #1;
        if (m_valid_o && m_ready_i) begin
            logic [32:0] e;
            if (q_beat.size() == 0) chk("R3 unexpected beat", m_data_o, '1);
            else begin
                e = q_beat.pop_front();
                chk("R3 beat data", m_data_o, e[31:0]);
                chk("R4 last flag", m_last_o, e[32]);
            end
        end
        if (md_valid_o) begin
            if (q_md.size() == 0) chk("R5 unexpected metadata", md_data_o, '1);
            else chk("R5 metadata", md_data_o, q_md.pop_front());
        end
        if (irq_o) irq_seen++;
    end

    task automatic pulse_start(input int a);
        @(negedge clk); desc_ptr_i = a; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic pulse_cont();
        @(negedge clk); cont_i = 1'b1;
        @(negedge clk); cont_i = 1'b0;
    endtask

    task automatic wait_done();
        int n;
        for (n = 0; n < 5000; n++) begin
            @(negedge clk);
            if (eol_o && q_rd.size() == 0 && q_beat.size() == 0 &&
                q_wr.size() == 0 && q_md.size() == 0) break;
        end
        if (n == 5000) chk("R8 chain did not finish", 1, 0);
        repeat (3) @(negedge clk);
        chk("R8 all expected items consumed",
            q_rd.size() + q_beat.size() + q_wr.size() + q_md.size(), 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE_0000 | i;
        mem[CTX >> 2] = 32'h0;
        put_desc(32'h100, 32'h110, 32'h200, 32'h1111_0010, 32'h20C);
        put_desc(32'h110, 32'h120, 32'h240, 32'h2222_0008, 32'h248);
        put_desc(32'h120, 32'h130, 32'h280, 32'h3333_0019, 32'h284);
        put_desc(32'h130, 32'h100, 32'h300, 32'h4444_0009, 32'h310);
        put_desc(32'h140, 32'h000, 32'h380, 32'h5555_0019, 32'h388);

        repeat (4) @(negedge clk);
        chk("R1 rd_req after reset", rd_req_o, 0);
        chk("R1 wr_req after reset", wr_req_o, 0);
        chk("R1 m_valid after reset", m_valid_o, 0);
        chk("R1 md_valid after reset", md_valid_o, 0);
        chk("R1 running after reset", running_o, 0);
        chk("R1 eol after reset", eol_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // three-descriptor chain, packet spans first two
        exp_pkt = 1'b1;
        expect_desc(32'h100); expect_desc(32'h110); expect_desc(32'h120);
        pulse_start(32'h100);
        wait_done();
        chk("R9 eol latched", eol_o, 1);
        chk("R12 running", running_o, 1);
        chk("R9 context disable word", mem[CTX >> 2], 32'h0000_8000);
        chk("R7 interrupt count", irq_seen, irq_exp);

        // continue ignored while stopped or disabled
        stop_i = 1'b1; pulse_cont(); repeat (20) @(negedge clk);
        chk("R11 eol kept while stopped", eol_o, 1);
        stop_i = 1'b0; enable_i = 1'b0; pulse_cont(); repeat (20) @(negedge clk);
        chk("R11 eol kept while disabled", eol_o, 1);
        enable_i = 1'b1;

        // continue with end of list still set
        expect_refetch(32'h120);
        pulse_cont(); repeat (20) @(negedge clk);
        chk("R10 reread done", q_rd.size(), 0);
        chk("R10 still halted", eol_o, 1);

        // software extends the chain
        mem[(32'h120 >> 2) + 2] = 32'h3333_0018;
        expect_refetch(32'h120); expect_desc(32'h130);
        pulse_cont(); repeat (10) @(negedge clk);
        chk("R10 eol cleared on continue", eol_o, 0);
        wait_done();
        chk("R10 eol latched after extension", eol_o, 1);
        chk("R7 interrupt count after extension", irq_seen, irq_exp);

        // fresh start from halt
        mem[CTX >> 2] = 32'h0;
        exp_pkt = 1'b1;
        expect_desc(32'h140);
        pulse_start(32'h140);
        @(negedge clk);
        chk("R12 eol cleared by start", eol_o, 0);
        chk("R12 running after start", running_o, 1);
        wait_done();
        chk("R9 context word rewritten", mem[CTX >> 2], 32'h0000_8000);
        chk("R7 interrupt count final", irq_seen, irq_exp);
        finish_run();
    end
endmodule